// File: doc/BRIEF.md
# Multi-Port Hot-Plug Interrupt Message Router

This block sits between a set of downstream serial-link ports and a single upstream message channel. It gathers hot-plug events, power-management events and general-purpose-event messages forwarded by the ports. It keeps a status bit for each port and each source, and it turns the combined state into assert and deassert messages sent upstream. The routing of a hot-plug event depends on enable bits checked in a fixed order. A global enable selects a general-purpose-event message. Otherwise the port's interrupt enable, together with its message-signalled-interrupt enable, selects a message-signalled interrupt carrying that port's address and data. Failing that, the port's legacy-interrupt disable bit selects a legacy level-interrupt message. If none of these applies, nothing is sent and software polls the status.

Each level-type message (hot-plug GPE, forwarded GPE, power-management GPE, legacy interrupt) follows the OR of the status bits of all ports. An assert goes out when the OR turns on and a deassert when it turns off, so the upstream side sees one edge per change. Message-signalled interrupts are single events, one per port event. All messages share one request/acknowledge handshake, and the block picks among them by fixed priority.

Top module: `hp_irq_router`

## Requirements
- R1: After reset `msg_req` is 0, `msg_type` is 0 and all status and sent-state is clear. No message leaves until an event arrives.
- R2: While `glb_hpgpe_en` is 1 and any port's slot-status bit is set, the upstream state is asserted hot-plug GPE: type 1 is sent when this turns true and type 2 when it turns false, whatever the per-port enables are.
- R3: A hot-plug event on port p, arriving with `glb_hpgpe_en`=0, `hp_int_en[p]`=1 and `msi_en[p]`=1, produces one type 7 message with `msg_port`=p, `msg_addr`=`msi_addr[p*AW +: AW]` and `msg_data`=`msi_data[p*DW +: DW]`. For every other type, port, address and data are 0.
- R4: The OR over ports of (slot status AND `glb_hpgpe_en`=0 AND `hp_int_en`=1 AND `msi_en`=0 AND `intx_dis`=0) drives the legacy interrupt: type 8 on its rise, type 9 on its fall.
- R5: A hot-plug event on a port with `hp_int_en`=0, or with `msi_en`=0 and `intx_dis`=1, while `glb_hpgpe_en`=0, produces no message. Only its status bit is set.
- R6: A per-port forwarded-GPE level is set by `gpe_asrt[p]` and cleared by `gpe_dsrt[p]`. If both arrive in the same cycle, the assert wins. The OR of these levels drives type 3 on its rise and type 4 on its fall.
- R7: `pme_evt[p]` sets a per-port power-management status bit. The OR of (status AND `pme_en`) drives type 5 on its rise and type 6 on its fall.
- R8: For each level type, exactly one message is sent per change of its aggregated condition. No message is repeated and none is sent with no change.
- R9: Slot and power-management status bits are write-1-to-clear through `hp_clr`/`pme_clr`. An event in the same cycle as a clear leaves the bit set.
- R10: Only one request is outstanding at a time. It is held with stable fields until `msg_ack`, and a new request may follow in the acknowledging cycle. Among pending messages the order is: hot-plug GPE, forwarded GPE, power-management GPE, message-signalled interrupts from the lowest port up, then legacy interrupt.
- R11: An event captured at a clock edge leads to its request becoming visible after the following edge, provided the handshake is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_hpgpe_en | input | 1 | Global enable for hot-plug GPE routing |
| hp_int_en | input | NPORTS | Per-port hot-plug interrupt enable |
| msi_en | input | NPORTS | Per-port message-signalled interrupt enable |
| intx_dis | input | NPORTS | Per-port legacy interrupt disable |
| pme_en | input | NPORTS | Per-port power-management status enable |
| hp_evt | input | NPORTS | Per-port hot-plug event pulse |
| hp_clr | input | NPORTS | Per-port slot-status write-1-to-clear |
| pme_evt | input | NPORTS | Per-port power-management event pulse |
| pme_clr | input | NPORTS | Per-port power-management status write-1-to-clear |
| gpe_asrt | input | NPORTS | Per-port forwarded GPE assert message |
| gpe_dsrt | input | NPORTS | Per-port forwarded GPE deassert message |
| msi_addr | input | NPORTS*AW | Message-signalled interrupt address, one field per port |
| msi_data | input | NPORTS*DW | Message-signalled interrupt data, one field per port |
| msg_ack | input | 1 | Upstream accepts the current request |
| msg_req | output | 1 | Upstream message request |
| msg_type | output | 4 | Message type code (see requirements) |
| msg_port | output | PW | Source port for type 7, else 0 |
| msg_addr | output | AW | Interrupt address for type 7, else 0 |
| msg_data | output | DW | Interrupt data for type 7, else 0 |

## Verification
The embedded assertions assume that `msg_ack` is meaningful only while `msg_req` is high. They also assume that event pulses and clears are one cycle wide and may coincide on the same port. The hold check relies on the upstream side never withdrawing a request without acknowledging it. The random stimulus keeps events and clears sparse and changes the routing enables only every hundred cycles, so that long stretches of each routing mode occur. Directed sequences force event-versus-clear collisions, simultaneous requests of every kind and held, unacknowledged requests.

// File: rtl/hpr_pkg.sv
package hpr_pkg;

    typedef enum logic [3:0] {
        MT_NONE      = 4'd0,
        MT_HPGPE_ON  = 4'd1,
        MT_HPGPE_OFF = 4'd2,
        MT_GPE_ON    = 4'd3,
        MT_GPE_OFF   = 4'd4,
        MT_PME_ON    = 4'd5,
        MT_PME_OFF   = 4'd6,
        MT_MSI       = 4'd7,
        MT_INTX_ON   = 4'd8,
        MT_INTX_OFF  = 4'd9
    } msg_type_e;

    localparam int NLVL     = 4;
    localparam int LV_HPGPE = 0;
    localparam int LV_GPE   = 1;
    localparam int LV_PME   = 2;
    localparam int LV_INTX  = 3;

    function automatic msg_type_e lvl_msg(input int lv, input logic on);
        msg_type_e t;
        case (lv)
            LV_HPGPE: t = on ? MT_HPGPE_ON : MT_HPGPE_OFF;
            LV_GPE:   t = on ? MT_GPE_ON   : MT_GPE_OFF;
            LV_PME:   t = on ? MT_PME_ON   : MT_PME_OFF;
            default:  t = on ? MT_INTX_ON  : MT_INTX_OFF;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/hpr_port_state.sv
module hpr_port_state (
    input  logic clk,
    input  logic rst_n,
    input  logic hp_evt,
    input  logic hp_clr,
    input  logic pme_evt,
    input  logic pme_clr,
    input  logic gpe_asrt,
    input  logic gpe_dsrt,
    input  logic msi_route,
    input  logic msi_take,
    output logic slot_sts,
    output logic pme_sts,
    output logic gpe_lvl,
    output logic msi_pend
);

    typedef struct packed {
        logic slot;
        logic pme;
        logic gpe;
        logic msip;
    } port_st_t;

    port_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.slot = hp_evt   | (st_q.slot & ~hp_clr);
        st_d.pme  = pme_evt  | (st_q.pme  & ~pme_clr);
        st_d.gpe  = gpe_asrt | (st_q.gpe  & ~gpe_dsrt);
        st_d.msip = (hp_evt & msi_route) | (st_q.msip & ~msi_take);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slot_sts = st_q.slot;
    assign pme_sts  = st_q.pme;
    assign gpe_lvl  = st_q.gpe;
    assign msi_pend = st_q.msip;

    // R9
    evt_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hp_evt |=> slot_sts);

    // R9
    clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_clr && !hp_evt) |=> !slot_sts);

    // R7
    pme_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pme_evt |=> pme_sts);

    // R6
    gpe_assert_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gpe_asrt |=> gpe_lvl);

endmodule

// File: rtl/hpr_msg_select.sv
module hpr_msg_select
    import hpr_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int PIDX_W = 2
) (
    input  logic [NLVL-1:0]   lvl_cond,
    input  logic [NLVL-1:0]   lvl_sent,
    input  logic [NPORTS-1:0] msi_pend,
    output logic              pick_vld,
    output msg_type_e         pick_type,
    output logic [PIDX_W-1:0] pick_port,
    output logic              pick_is_msi,
    output logic [NLVL-1:0]   pick_lvl_oh
);

    always_comb begin
        pick_vld    = 1'b0;
        pick_type   = MT_NONE;
        pick_port   = '0;
        pick_is_msi = 1'b0;
        pick_lvl_oh = '0;
        // GPE class first, in fixed order
        for (int lv = LV_HPGPE; lv <= LV_PME; lv++) begin
            if (!pick_vld && (lvl_cond[lv] != lvl_sent[lv])) begin
                pick_vld        = 1'b1;
                pick_type       = lvl_msg(lv, lvl_cond[lv]);
                pick_lvl_oh[lv] = 1'b1;
            end
        end
        // then message-signalled interrupts, lowest port first
        for (int p = 0; p < NPORTS; p++) begin
            if (!pick_vld && msi_pend[p]) begin
                pick_vld    = 1'b1;
                pick_type   = MT_MSI;
                pick_port   = PIDX_W'(p);
                pick_is_msi = 1'b1;
            end
        end
        // legacy interrupt last
        if (!pick_vld && (lvl_cond[LV_INTX] != lvl_sent[LV_INTX])) begin
            pick_vld             = 1'b1;
            pick_type            = lvl_msg(LV_INTX, lvl_cond[LV_INTX]);
            pick_lvl_oh[LV_INTX] = 1'b1;
        end
    end

endmodule

// File: rtl/hp_irq_router.sv
module hp_irq_router
    import hpr_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int AW     = 32,
    parameter int DW     = 32,
    parameter int PW     = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 glb_hpgpe_en,
    input  logic [NPORTS-1:0]    hp_int_en,
    input  logic [NPORTS-1:0]    msi_en,
    input  logic [NPORTS-1:0]    intx_dis,
    input  logic [NPORTS-1:0]    pme_en,
    input  logic [NPORTS-1:0]    hp_evt,
    input  logic [NPORTS-1:0]    hp_clr,
    input  logic [NPORTS-1:0]    pme_evt,
    input  logic [NPORTS-1:0]    pme_clr,
    input  logic [NPORTS-1:0]    gpe_asrt,
    input  logic [NPORTS-1:0]    gpe_dsrt,
    input  logic [NPORTS*AW-1:0] msi_addr,
    input  logic [NPORTS*DW-1:0] msi_data,
    input  logic                 msg_ack,
    output logic                 msg_req,
    output logic [3:0]           msg_type,
    output logic [PW-1:0]        msg_port,
    output logic [AW-1:0]        msg_addr,
    output logic [DW-1:0]        msg_data
);

    typedef struct packed {
        logic            req;
        msg_type_e       mtype;
        logic [PW-1:0]   port;
        logic [AW-1:0]   addr;
        logic [DW-1:0]   data;
        logic [NLVL-1:0] sent;
    } out_st_t;

    out_st_t st_d, st_q;

    logic [NPORTS-1:0] slot_sts, pme_sts, gpe_lvl, msi_pend;
    logic [NPORTS-1:0] msi_route, intx_route, msi_take;
    logic [NLVL-1:0]   lvl_cond, pick_lvl_oh;
    logic              pick_vld, pick_is_msi, free, launch;
    msg_type_e         pick_type;
    logic [PW-1:0]     pick_port;

    assign free   = !st_q.req || msg_ack;
    assign launch = free && pick_vld;

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        assign msi_route[p]  = !glb_hpgpe_en && hp_int_en[p] && msi_en[p];
        assign intx_route[p] = !glb_hpgpe_en && hp_int_en[p] && !msi_en[p] && !intx_dis[p];
        assign msi_take[p]   = launch && pick_is_msi && (pick_port == PW'(p));

        hpr_port_state u_state (
            .clk       (clk),
            .rst_n     (rst_n),
            .hp_evt    (hp_evt[p]),
            .hp_clr    (hp_clr[p]),
            .pme_evt   (pme_evt[p]),
            .pme_clr   (pme_clr[p]),
            .gpe_asrt  (gpe_asrt[p]),
            .gpe_dsrt  (gpe_dsrt[p]),
            .msi_route (msi_route[p]),
            .msi_take  (msi_take[p]),
            .slot_sts  (slot_sts[p]),
            .pme_sts   (pme_sts[p]),
            .gpe_lvl   (gpe_lvl[p]),
            .msi_pend  (msi_pend[p])
        );
    end

    assign lvl_cond[LV_HPGPE] = glb_hpgpe_en && (|slot_sts);
    assign lvl_cond[LV_GPE]   = |gpe_lvl;
    assign lvl_cond[LV_PME]   = |(pme_sts & pme_en);
    assign lvl_cond[LV_INTX]  = |(slot_sts & intx_route);

    hpr_msg_select #(.NPORTS(NPORTS), .PIDX_W(PW)) u_sel (
        .lvl_cond    (lvl_cond),
        .lvl_sent    (st_q.sent),
        .msi_pend    (msi_pend),
        .pick_vld    (pick_vld),
        .pick_type   (pick_type),
        .pick_port   (pick_port),
        .pick_is_msi (pick_is_msi),
        .pick_lvl_oh (pick_lvl_oh)
    );

    always_comb begin
        st_d = st_q;
        if (free) begin
            st_d.req   = pick_vld;
            st_d.mtype = pick_vld ? pick_type : MT_NONE;
            st_d.port  = '0;
            st_d.addr  = '0;
            st_d.data  = '0;
            if (launch && pick_is_msi) begin
                st_d.port = pick_port;
                st_d.addr = msi_addr[int'(pick_port)*AW +: AW];
                st_d.data = msi_data[int'(pick_port)*DW +: DW];
            end
            if (launch) st_d.sent = st_q.sent ^ pick_lvl_oh;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{req: 1'b0, mtype: MT_NONE, default: '0};
        else        st_q <= st_d;
    end

    assign msg_req  = st_q.req;
    assign msg_type = st_q.mtype;
    assign msg_port = st_q.port;
    assign msg_addr = st_q.addr;
    assign msg_data = st_q.data;

    // R10
    hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_req && !msg_ack) |=> (msg_req && $stable(msg_type) && $stable(msg_port)
                                   && $stable(msg_addr) && $stable(msg_data)));

    // R3
    non_msi_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_req && msg_type != MT_MSI) |-> (msg_port == '0 && msg_addr == '0 && msg_data == '0));

    // R1
    idle_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_req |-> (msg_type == MT_NONE));

    // R2
    hpgpe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && pick_type == MT_HPGPE_ON) |-> (glb_hpgpe_en && (|slot_sts)));

endmodule

// File: tb/tb_hp_irq_router.sv
`timescale 1ns/1ps
module tb_hp_irq_router;

    localparam int N  = 4;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int PW = 2;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n;
    logic          glb_hpgpe_en;
    logic [N-1:0]  hp_int_en, msi_en, intx_dis, pme_en;
    logic [N-1:0]  hp_evt, hp_clr, pme_evt, pme_clr, gpe_asrt, gpe_dsrt;
    logic [N*AW-1:0] msi_addr;
    logic [N*DW-1:0] msi_data;
    logic          msg_ack;
    logic          msg_req;
    logic [3:0]    msg_type;
    logic [PW-1:0] msg_port;
    logic [AW-1:0] msg_addr;
    logic [DW-1:0] msg_data;

    hp_irq_router #(.NPORTS(N), .AW(AW), .DW(DW), .PW(PW)) dut (
        .clk(clk), .rst_n(rst_n), .glb_hpgpe_en(glb_hpgpe_en),
        .hp_int_en(hp_int_en), .msi_en(msi_en), .intx_dis(intx_dis), .pme_en(pme_en),
        .hp_evt(hp_evt), .hp_clr(hp_clr), .pme_evt(pme_evt), .pme_clr(pme_clr),
        .gpe_asrt(gpe_asrt), .gpe_dsrt(gpe_dsrt),
        .msi_addr(msi_addr), .msi_data(msi_data), .msg_ack(msg_ack),
        .msg_req(msg_req), .msg_type(msg_type), .msg_port(msg_port),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    int nvec = 0;
    int nerr = 0;
    bit finished = 0;

    // reference state, built from the requirements
    bit [N-1:0] m_slot, m_pme, m_gpe, m_msip;
    bit [3:0]   m_sent;
    bit         m_req;
    int         m_type, m_port;
    bit [31:0]  m_addr, m_data;

    function automatic string tag_of(int t);
        case (t)
            1, 2:    return "R2";
            3, 4:    return "R6";
            5, 6:    return "R7";
            7:       return "R3";
            8, 9:    return "R4";
            default: return "R8";
        endcase
    endfunction

    function automatic bit [N-1:0] sparse(int odds);
        bit [N-1:0] v;
        for (int i = 0; i < N; i++) v[i] = ($urandom_range(odds - 1) == 0);
        return v;
    endfunction

    task automatic model_reset();
        m_slot = '0; m_pme = '0; m_gpe = '0; m_msip = '0; m_sent = '0;
        m_req = 0; m_type = 0; m_port = 0; m_addr = '0; m_data = '0;
    endtask

    task automatic model_edge();
        bit [N-1:0] msir, intxr;
        bit [3:0] cond;
        bit found;
        int ptype, pport, take, lv;
        for (int p = 0; p < N; p++) begin
            msir[p]  = !glb_hpgpe_en && hp_int_en[p] && msi_en[p];
            intxr[p] = !glb_hpgpe_en && hp_int_en[p] && !msi_en[p] && !intx_dis[p];
        end
        cond[0] = glb_hpgpe_en && (|m_slot);
        cond[1] = |m_gpe;
        cond[2] = |(m_pme & pme_en);
        cond[3] = |(m_slot & intxr);
        found = 0; ptype = 0; pport = 0; take = -1; lv = -1;
        for (int k = 0; k < 3; k++)
            if (!found && cond[k] != m_sent[k]) begin
                found = 1; lv = k; ptype = 2*k + (cond[k] ? 1 : 2);
            end
        for (int p = 0; p < N; p++)
            if (!found && m_msip[p]) begin
                found = 1; ptype = 7; pport = p; take = p;
            end
        if (!found && cond[3] != m_sent[3]) begin
            found = 1; lv = 3; ptype = cond[3] ? 8 : 9;
        end
        if (!m_req || msg_ack) begin
            m_req = found; m_type = ptype; m_port = pport;
            m_addr = (take >= 0) ? msi_addr[take*AW +: AW] : '0;
            m_data = (take >= 0) ? msi_data[take*DW +: DW] : '0;
            if (lv >= 0) m_sent[lv] = ~m_sent[lv];
            if (take >= 0) m_msip[take] = 1'b0;
        end
        m_msip = m_msip | (hp_evt & msir);
        m_slot = hp_evt | (m_slot & ~hp_clr);
        m_pme  = pme_evt | (m_pme & ~pme_clr);
        m_gpe  = gpe_asrt | (m_gpe & ~gpe_dsrt);
    endtask

    task automatic compare(string tag);
        string t;
        bit bad;
        t = (tag != "") ? tag : (m_req ? tag_of(m_type) : "R8");
        nvec++;
        bad = (msg_req !== m_req) || (msg_type !== 4'(m_type));
        if (m_req)
            bad = bad || (msg_port !== PW'(m_port)) || (msg_addr !== m_addr) || (msg_data !== m_data);
        if (bad) begin
            nerr++;
            $display("FAIL %s: got req=%0d type=%0d port=%0d addr=%h data=%h, expected req=%0d type=%0d port=%0d addr=%h data=%h",
                     t, msg_req, msg_type, msg_port, msg_addr, msg_data,
                     m_req, m_type, m_port, m_addr, m_data);
        end
    endtask

    task automatic clear_pulses();
        hp_evt = '0; hp_clr = '0; pme_evt = '0; pme_clr = '0; gpe_asrt = '0; gpe_dsrt = '0;
    endtask

    // one clock: inputs already set, model follows the edge, outputs checked mid-cycle
    task automatic cycle(string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
        clear_pulses();
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) cycle(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nerr++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0; glb_hpgpe_en = 0; hp_int_en = '0; msi_en = '0; intx_dis = '0; pme_en = '0;
        msg_ack = 0; clear_pulses();
        for (int p = 0; p < N; p++) begin
            msi_addr[p*AW +: AW] = $urandom();
            msi_data[p*DW +: DW] = $urandom();
        end
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        compare("R1");
        idle(2, "R1");

        // R2 and R11: global GPE routing, latency of two edges
        msg_ack = 1; glb_hpgpe_en = 1; hp_int_en = '1; msi_en = 4'b0101;
        hp_evt = 4'b0100;
        cycle("R11");
        cycle("R11");
        idle(2, "");
        hp_clr = 4'b0100;
        idle(4, "");

        // R5: no routing leaves events for polling
        glb_hpgpe_en = 0; hp_int_en = '0;
        hp_evt = 4'b1111;
        idle(5, "R5");
        hp_int_en = '1; msi_en = '0; intx_dis = '1;
        hp_evt = 4'b1111;
        idle(5, "R5");
        hp_clr = 4'b1111;
        idle(2, "R5");

        // R3 and R10: two interrupts, held without acknowledge
        msi_en = '1; intx_dis = '0; msg_ack = 0;
        hp_evt = 4'b1010;
        idle(4, "R10");
        msg_ack = 1;
        idle(3, "");
        hp_clr = 4'b1010;
        idle(2, "");

        // R9: event and clear on the same cycle keep the status
        msi_en = '0;
        hp_evt = 4'b0001; hp_clr = 4'b0001;
        idle(3, "R9");
        hp_evt = 4'b0010;
        idle(3, "R8");
        hp_clr = 4'b0011;
        idle(3, "R9");

        // R10: every kind pending at once
        msi_en = 4'b1000; pme_en = '1;
        gpe_asrt = 4'b0010; pme_evt = 4'b0100; hp_evt = 4'b1001;
        idle(8, "R10");
        gpe_dsrt = 4'b0010; gpe_asrt = 4'b0001; pme_clr = 4'b0100;
        idle(3, "R6");
        gpe_dsrt = 4'b0001; hp_clr = 4'b1111;
        idle(6, "");

        // random phase
        for (int i = 0; i < 6000; i++) begin
            if (i % 100 == 0) begin
                glb_hpgpe_en = ($urandom_range(3) == 0);
                hp_int_en = 4'($urandom()); msi_en = 4'($urandom());
                intx_dis = 4'($urandom()); pme_en = 4'($urandom());
            end
            msg_ack  = $urandom_range(1);
            hp_evt   = sparse(10); hp_clr  = sparse(8);
            pme_evt  = sparse(12); pme_clr = sparse(8);
            gpe_asrt = sparse(14); gpe_dsrt = sparse(8);
            cycle("");
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

endmodule